// File: doc/BRIEF.md
# Synchronous Codec Serial Port

This block is a full-duplex serial port for a codec or an ADC/DAC pair. It has one transmit section and one receive section, and the two run independently. The external bit clocks, the frame-sync inputs and the serial data input are not used as clocks. The system clock samples them through a short synchronizer chain and edge detectors, so every serial event becomes a single-cycle strobe in the system clock domain. The chain adds a few system cycles of latency, and the serial clocks must run well below the system clock.

The transmit section holds a word written by the host. When a frame starts, it loads that word into a shift register and drives it out most-significant bit first, changing bits on rising edges of the transmit bit clock. A frame starts on a falling edge of the transmit frame-sync pin. In internal mode, the port instead generates its own frame pulse after each host write. The receive section waits for a falling edge of its frame-sync pin, then gathers bits on falling edges of the receive bit clock. When the word is complete it copies it into a holding register. Each direction gives a one-cycle completion strobe to the interrupt logic. A frame sync that arrives in the middle of a word restarts that direction cleanly.

Top module: `codec_serial_port`

## Requirements
- R1: After reset, the receive holding register and the transmit data register read 0. `xdat_oe` is 0, `xfs_oe` is 0 (external frame-sync mode) and `xfs_out` is 1.
- R2: In external mode, a falling edge on `xfs_in` loads the transmit data register into the shift register and presents bit 15 on `xdat_out`. Each later rising edge of `xclk` presents the next lower bit, so the word goes out most-significant bit first.
- R3: `xdat_oe` is 1 from frame start until the rising `xclk` edge that follows bit 0, and 0 at every other time.
- R4: `tx_done` pulses for exactly one cycle when a word ends, in the cycle `xdat_oe` falls.
- R5: After a falling edge of `rfs`, each of the next 16 falling `rclk` edges shifts in `rdat`, most-significant bit first. On the 16th edge the word enters the receive holding register, and `rx_done` pulses for one cycle in that same cycle.
- R6: A falling `xfs_in` edge during a transmit word drops the word without a `tx_done`. It then reloads the current transmit data register and sends a full 16-bit word.
- R7: A falling `rfs` edge during a receive word discards the partial bits and starts a new 16-bit word. Only the new word produces `rx_done`.
- R8: When mode bit 0 is 1 (internal mode), `xfs_oe` is 1 and `xfs_in` is ignored. A transmit data write arms a frame. The first rising `xclk` edge while idle starts it, with `xfs_out` low for one cycle.
- R9: Host write address 0 selects the transmit data register and address 1 selects the mode register (bit 0 = internal frame sync). Read address 0 returns the receive holding register and read address 1 returns the transmit data register.
- R10: Bit-clock edges outside a frame have no effect: no `xdat_oe`, no `tx_done`, no `rx_done`, and the holding register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | Host write select: 0 transmit data, 1 mode |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 1 | Host read select: 0 receive holding, 1 transmit data |
| rd_data | output | 16 | Host read data (combinational) |
| rclk | input | 1 | Receive bit clock (sampled) |
| rfs | input | 1 | Receive frame sync, falling-edge active |
| rdat | input | 1 | Receive serial data |
| xclk | input | 1 | Transmit bit clock (sampled) |
| xfs_in | input | 1 | Transmit frame sync input, falling-edge active |
| xdat_out | output | 1 | Transmit serial data |
| xdat_oe | output | 1 | Tri-state enable for `xdat_out` |
| xfs_out | output | 1 | Generated transmit frame sync, active low |
| xfs_oe | output | 1 | Enable for `xfs_out` |
| rx_done | output | 1 | Receive word complete strobe |
| tx_done | output | 1 | Transmit word complete strobe |

## Verification
The bench builds the port with its defaults: a 16-bit word and a two-stage synchronizer. With these settings, any pin edge reaches the shift logic within three system cycles. The bench holds each serial clock phase for six system cycles, so it can sample outputs at fixed points with margin. This brings within reach the restart of both directions mid-word, the internal frame pulse and the ignored frame input in internal mode, and idle clock edges.

// File: rtl/csp_pkg.sv
package csp_pkg;
   // What a pin sampler reports after synchronization
   typedef enum logic [1:0] {
      SMP_LEVEL = 2'd0,
      SMP_RISE  = 2'd1,
      SMP_FALL  = 2'd2
   } smp_kind_e;

   // Host register select
   typedef enum logic {
      CSP_REG_TXD  = 1'b0,
      CSP_REG_MODE = 1'b1
   } csp_reg_e;
endpackage

// File: rtl/csp_pin_sampler.sv
module csp_pin_sampler #(
   parameter int                  STAGES = 2,
   parameter csp_pkg::smp_kind_e  KIND   = csp_pkg::SMP_LEVEL
) (
   input  logic clk,
   input  logic rst,
   input  logic pin,
   output logic ev
);
   if (STAGES < 1) begin : g_bad_stages
      $error("csp_pin_sampler: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;
   logic              level;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (rst) chain <= 1'b1;
         else     chain <= pin;
      end
   end else begin : g_many
      always_ff @(posedge clk) begin
         if (rst) chain <= '1;
         else     chain <= {chain[STAGES-2:0], pin};
      end
   end

   assign level = chain[STAGES-1];

   if (KIND == csp_pkg::SMP_LEVEL) begin : g_level
      assign ev = level;
   end else begin : g_edge
      logic prev;
      always_ff @(posedge clk) begin
         if (rst) prev <= 1'b1;
         else     prev <= level;
      end
      if (KIND == csp_pkg::SMP_RISE) begin : g_rise
         assign ev = level & ~prev;
      end else begin : g_fall
         assign ev = ~level & prev;
      end
   end
endmodule

// File: rtl/csp_rx.sv
module csp_rx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_ev,
   input  logic              bclk_ev,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word,
   output logic              done
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg <= '0;
         word  <= '0;
         cnt   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (frame_ev) begin
            // new frame always wins, partial bits are dropped
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy && bclk_ev) begin
            shreg <= {shreg[WORD_W-2:0], bit_in};
            if (cnt == LAST) begin
               busy <= 1'b0;
               cnt  <= '0;
               word <= {shreg[WORD_W-2:0], bit_in};
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/csp_tx.sv
module csp_tx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              bclk_ev,
   input  logic [WORD_W-1:0] load_word,
   output logic              sd,
   output logic              oe,
   output logic              done
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg <= '0;
         cnt   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            shreg <= load_word;
            cnt   <= '0;
            busy  <= 1'b1;
         end else if (busy && bclk_ev) begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               cnt  <= '0;
               done <= 1'b1;
            end else begin
               shreg <= {shreg[WORD_W-2:0], 1'b0};
               cnt   <= cnt + 1'b1;
            end
         end
      end
   end

   assign sd = shreg[WORD_W-1] & busy;
   assign oe = busy;
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port #(
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_addr,
   output logic [WORD_W-1:0] rd_data,
   input  logic              rclk,
   input  logic              rfs,
   input  logic              rdat,
   input  logic              xclk,
   input  logic              xfs_in,
   output logic              xdat_out,
   output logic              xdat_oe,
   output logic              xfs_out,
   output logic              xfs_oe,
   output logic              rx_done,
   output logic              tx_done
);
   import csp_pkg::*;

   if (WORD_W != 16) begin : g_bad_word
      $error("codec_serial_port: only a 16-bit word is supported");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("codec_serial_port: SYNC_STAGES must lie in 1..4");
   end

   logic rclk_fall, rfs_fall, rdat_lvl, xclk_rise, xfs_fall;

   csp_pin_sampler #(.STAGES(SYNC_STAGES), .KIND(SMP_FALL))  u_s_rclk
      (.clk(clk), .rst(rst), .pin(rclk),   .ev(rclk_fall));
   csp_pin_sampler #(.STAGES(SYNC_STAGES), .KIND(SMP_FALL))  u_s_rfs
      (.clk(clk), .rst(rst), .pin(rfs),    .ev(rfs_fall));
   csp_pin_sampler #(.STAGES(SYNC_STAGES), .KIND(SMP_LEVEL)) u_s_rdat
      (.clk(clk), .rst(rst), .pin(rdat),   .ev(rdat_lvl));
   csp_pin_sampler #(.STAGES(SYNC_STAGES), .KIND(SMP_RISE))  u_s_xclk
      (.clk(clk), .rst(rst), .pin(xclk),   .ev(xclk_rise));
   csp_pin_sampler #(.STAGES(SYNC_STAGES), .KIND(SMP_FALL))  u_s_xfs
      (.clk(clk), .rst(rst), .pin(xfs_in), .ev(xfs_fall));

   // Host registers
   logic [WORD_W-1:0] txd_q;
   logic              mode_int_q;
   logic              armed_q;
   logic              xfs_n_q;
   logic [WORD_W-1:0] rx_word;
   logic              tx_busy;
   logic              start_int, start_ext, tx_start;
   logic              wr_txd, wr_mode;

   assign wr_txd  = wr_en && (wr_addr == CSP_REG_TXD);
   assign wr_mode = wr_en && (wr_addr == CSP_REG_MODE);

   assign start_int = mode_int_q & armed_q & xclk_rise & ~tx_busy;
   assign start_ext = ~mode_int_q & xfs_fall;
   assign tx_start  = start_int | start_ext;

   always_ff @(posedge clk) begin
      if (rst) begin
         txd_q      <= '0;
         mode_int_q <= 1'b0;
         armed_q    <= 1'b0;
         xfs_n_q    <= 1'b1;
      end else begin
         if (wr_txd)  txd_q      <= wr_data;
         if (wr_mode) mode_int_q <= wr_data[0];

         if (wr_mode && !wr_data[0])          armed_q <= 1'b0;
         else if (wr_txd && mode_int_q)       armed_q <= 1'b1;
         else if (start_int)                  armed_q <= 1'b0;

         xfs_n_q <= ~start_int;
      end
   end

   csp_rx #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst(rst), .frame_ev(rfs_fall), .bclk_ev(rclk_fall),
      .bit_in(rdat_lvl), .word(rx_word), .done(rx_done)
   );

   csp_tx #(.WORD_W(WORD_W)) u_tx (
      .clk(clk), .rst(rst), .start(tx_start), .bclk_ev(xclk_rise),
      .load_word(txd_q), .sd(xdat_out), .oe(tx_busy), .done(tx_done)
   );

   assign xdat_oe = tx_busy;
   assign xfs_out = xfs_n_q;
   assign xfs_oe  = mode_int_q;
   assign rd_data = (rd_addr == 1'b1) ? txd_q : rx_word;
endmodule

// File: rtl/csp_checker.sv
module csp_checker (
   input logic clk,
   input logic rst,
   input logic xdat_oe,
   input logic xfs_out,
   input logic rx_done,
   input logic tx_done
);
   // R3
   oe_drop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(xdat_oe) |-> tx_done);

   // R4
   tx_done_single_chk: assert property (@(posedge clk) disable iff (rst)
      tx_done |=> !tx_done);

   // R4
   tx_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      tx_done |-> !xdat_oe);

   // R5
   rx_done_single_chk: assert property (@(posedge clk) disable iff (rst)
      rx_done |=> !rx_done);

   // R8
   fs_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      !xfs_out |=> xfs_out);

   // R8
   fs_pulse_starts_word_chk: assert property (@(posedge clk) disable iff (rst)
      !xfs_out |-> xdat_oe);
endmodule

bind codec_serial_port csp_checker i_csp_checker (
   .clk(clk), .rst(rst), .xdat_oe(xdat_oe), .xfs_out(xfs_out),
   .rx_done(rx_done), .tx_done(tx_done)
);

// File: tb/test_codec_serial_port.sv
module test_codec_serial_port;
   localparam int CLK_PERIOD = 10;
   localparam int H          = 6;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        rclk = 1'b1, rfs = 1'b1, rdat = 1'b0;
   logic        xclk = 1'b1, xfs_in = 1'b1;
   logic        xdat_out, xdat_oe, xfs_out, xfs_oe, rx_done, tx_done;

   int n_vec = 0, n_bad = 0;
   int tx_done_cnt = 0, rx_done_cnt = 0, fs_lo_cnt = 0;
   logic [15:0] tx_cap = '0;
   logic [15:0] tx_exp[$];
   logic [15:0] rx_exp[$];
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   codec_serial_port i_codec_serial_port (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .rclk(rclk), .rfs(rfs), .rdat(rdat),
      .xclk(xclk), .xfs_in(xfs_in), .xdat_out(xdat_out), .xdat_oe(xdat_oe),
      .xfs_out(xfs_out), .xfs_oe(xfs_oe), .rx_done(rx_done), .tx_done(tx_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_wr(input logic a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(1);
      wr_en = 1'b0;
      tick(1);
   endtask

   // Monitor: pops expected words as completion strobes appear
   always @(negedge clk) begin
      if (!rst) begin
         if (tx_done) begin
            tx_done_cnt++;
            if (tx_exp.size() == 0) chk("R6 unexpected tx_done", 32'd1, 32'd0);
            else chk("R2 tx word", {16'd0, tx_cap}, {16'd0, tx_exp.pop_front()});
         end
         if (rx_done) begin
            rx_done_cnt++;
            if (rx_exp.size() == 0) chk("R7 unexpected rx_done", 32'd1, 32'd0);
            else chk("R5 rx word", {16'd0, rd_data}, {16'd0, rx_exp.pop_front()});
         end
         if (!xfs_out) fs_lo_cnt++;
      end
   end

   // Capture transmit bits; nbits < 16 leaves the word unfinished
   task automatic tx_shift(input int nbits, input bit poke_fs);
      logic [15:0] cap = '0;
      for (int i = 0; i < nbits; i++) begin
         cap[15-i] = xdat_out;
         if (i == 1) chk("R3 oe mid-word", {31'd0, xdat_oe}, 32'd1);
         if (poke_fs && i == 4) begin
            xfs_in = 1'b0; tick(H); xfs_in = 1'b1; tick(H);
         end
         if (i == 15) tx_cap = cap;
         xclk = 1'b1; tick(H);
         xclk = 1'b0; tick(H);
      end
   endtask

   task automatic ext_frame_start;
      xclk = 1'b0; tick(H);
      xfs_in = 1'b0; tick(H);
      xfs_in = 1'b1; tick(H);
   endtask

   task automatic rx_send(input logic [15:0] w, input int nbits);
      if (nbits == 16) rx_exp.push_back(w);
      rfs = 1'b0; tick(H);
      rfs = 1'b1; tick(H);
      for (int i = 0; i < nbits; i++) begin
         rdat = w[15-i];
         rclk = 1'b1; tick(H);
         rclk = 1'b0; tick(H);
      end
      rclk = 1'b1; tick(H);
   endtask

   initial begin
      int t0, r0;
      tick(4);
      rst = 1'b0;
      tick(2);
      // R1 reset state
      chk("R1 rx holding", {16'd0, rd_data}, 32'd0);
      rd_addr = 1'b1; tick(1);
      chk("R1 tx data", {16'd0, rd_data}, 32'd0);
      rd_addr = 1'b0;
      chk("R1 xdat_oe", {31'd0, xdat_oe}, 32'd0);
      chk("R1 xfs_oe", {31'd0, xfs_oe}, 32'd0);
      chk("R1 xfs_out", {31'd0, xfs_out}, 32'd1);

      // R9 host write/read of transmit data
      host_wr(1'b0, 16'hA53C);
      rd_addr = 1'b1; tick(1);
      chk("R9 txd readback", {16'd0, rd_data}, 32'h0000A53C);
      rd_addr = 1'b0; tick(1);

      // R10 idle clock edges
      t0 = tx_done_cnt; r0 = rx_done_cnt;
      for (int k = 0; k < 3; k++) begin
         xclk = 1'b0; rclk = 1'b0; tick(H);
         xclk = 1'b1; rclk = 1'b1; tick(H);
         chk("R10 idle oe", {31'd0, xdat_oe}, 32'd0);
      end
      chk("R10 no tx_done", tx_done_cnt, t0);
      chk("R10 no rx_done", rx_done_cnt, r0);
      chk("R10 rx holding", {16'd0, rd_data}, 32'd0);

      // R2/R3/R4 external frame transmit
      tx_exp.push_back(16'hA53C);
      t0 = tx_done_cnt;
      ext_frame_start();
      chk("R3 oe at start", {31'd0, xdat_oe}, 32'd1);
      tx_shift(16, 0);
      chk("R3 oe after word", {31'd0, xdat_oe}, 32'd0);
      chk("R4 one tx_done", tx_done_cnt, t0 + 1);

      // R2 second pattern
      host_wr(1'b0, 16'h8001);
      tx_exp.push_back(16'h8001);
      ext_frame_start();
      tx_shift(16, 0);

      // R6 mid-word restart with reload
      host_wr(1'b0, 16'h1234);
      t0 = tx_done_cnt;
      ext_frame_start();
      tx_shift(5, 0);
      host_wr(1'b0, 16'hFE17);
      tx_exp.push_back(16'hFE17);
      xfs_in = 1'b0; tick(H);
      xfs_in = 1'b1; tick(H);
      tx_shift(16, 0);
      chk("R6 single done after restart", tx_done_cnt, t0 + 1);

      // R5 receive two patterns
      r0 = rx_done_cnt;
      rx_send(16'hC0DE, 16);
      rx_send(16'h0001, 16);
      chk("R5 two rx_done", rx_done_cnt, r0 + 2);

      // R7 mid-word receive restart
      r0 = rx_done_cnt;
      rx_send(16'hFFFF, 6);
      rx_send(16'h5AA5, 16);
      chk("R7 single rx_done", rx_done_cnt, r0 + 1);
      chk("R7 holding value", {16'd0, rd_data}, 32'h00005AA5);

      // R8 internal frame sync
      host_wr(1'b1, 16'h0001);
      chk("R8 xfs_oe", {31'd0, xfs_oe}, 32'd1);
      xclk = 1'b0; tick(H);
      xfs_in = 1'b0; tick(H); xfs_in = 1'b1; tick(H);
      chk("R8 xfs_in ignored", {31'd0, xdat_oe}, 32'd0);
      fs_lo_cnt = 0;
      host_wr(1'b0, 16'h3C96);
      tx_exp.push_back(16'h3C96);
      t0 = tx_done_cnt;
      xclk = 1'b1; tick(H);
      xclk = 1'b0; tick(H);
      chk("R8 fs pulse once", fs_lo_cnt, 1);
      chk("R8 oe after internal start", {31'd0, xdat_oe}, 32'd1);
      tx_shift(16, 1);
      chk("R8 one done despite xfs_in", tx_done_cnt, t0 + 1);
      chk("R8 no extra pulse", fs_lo_cnt, 1);

      tick(4);
      chk("R2 tx queue drained", tx_exp.size(), 0);
      chk("R5 rx queue drained", rx_exp.size(), 0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule